// File: doc/BRIEF.md
# Descriptor Ring DMA Pipe Engine

The block runs a single DMA pipe driven by a circular ring of 8-byte descriptors in system memory. Software sets the ring base and ring size, enables the pipe with a direction, and then writes a producer byte offset. The pipe has no start bit. It runs whenever the producer offset differs from its own consumer offset.

For each descriptor, the engine reads one 64-bit word through a memory read port. It issues one move request to a downstream data mover and waits for that mover's done pulse. It then steps the consumer offset, wrapping at the ring size. Flag bits in the descriptor decide which per-pipe status events are raised. An interrupt line is the OR of the enabled status bits.

Descriptor word layout: bits 31:0 hold the buffer address, bits 47:32 the byte count, and bits 63:48 the flags. Within the flags, bit 15 requests an interrupt, bit 14 marks end of transfer, bit 13 marks end of block, and bit 12 is the write fence. Registers are selected by a 4-bit word index on `regAddr`. Reads are combinational.

Top module: `ring_pipe_engine`

## Requirements
- R1: After `rstN` is released, the consumer offset (index 6) and the status (index 8) read 0, `irq` is 0, and neither `memRdReq` nor `moveReq` is asserted.
- R2: Each fetch reads address base + consumer offset. The move request that follows carries the descriptor's address and byte count. It also carries the direction from control bit 3, system mode from control bit 5, the fence from flag bit 12 and end-of-block from flag bit 13. The request is held until `moveDone`.
- R3: With the pipe enabled (control register index 0, bit 1), descriptors are processed in ring order until the consumer offset equals the producer offset (index 5). With enable clear, no descriptor is fetched.
- R4: The consumer offset advances by 8 after each completed move and wraps to 0 when it reaches the ring size (index 4). It reads back in the low 16 bits of index 6.
- R5: A producer write whose value is not a multiple of 8, or is not below the ring size, leaves the producer offset unchanged and sets status bit 4 (error).
- R6: Status bit 0 (descriptor processed) is set only by a descriptor with flag bit 15. Status bit 5 (end of transfer) is set only by a descriptor with flag bit 14.
- R7: Status bit 3 (out of descriptors) is set when a completed descriptor makes the consumer offset equal to the producer offset.
- R8: Writing a pattern to index 9 clears those status bits. `irq` equals the OR of status ANDed with the enable mask at index 7.
- R9: Writing 1 to the halt register (index 2, bit 0) stops new fetches. Writing 0 resumes processing.
- R10: Writing 1 and then 0 to the pipe reset register (index 1, bit 0) returns control, base, size, producer, consumer, enables and status to 0.
- R11: The ring base (index 3) ignores the low 3 bits of a write and reads them as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| memRdReq | output | 1 | Descriptor read request, held until `memRdValid` |
| memRdAddr | output | 32 | Descriptor byte address |
| memRdValid | input | 1 | Descriptor read data valid (one cycle) |
| memRdData | input | 64 | Descriptor word |
| moveReq | output | 1 | Move request, held until `moveDone` |
| moveAddr | output | 32 | Buffer address of the move |
| moveLen | output | 16 | Byte count of the move |
| moveDir | output | 1 | 1: peripheral to memory |
| moveSysMode | output | 1 | System mode selection |
| moveFence | output | 1 | Mover must commit writes before `moveDone` |
| moveEob | output | 1 | End-of-block marker of the descriptor |
| moveDone | input | 1 | Mover completion pulse |
| irq | output | 1 | Pipe interrupt |

## Verification
The hardest state to reach is a consumer offset that wraps mid-batch, where the producer offset sits numerically below the consumer offset. Reaching it requires a first batch that leaves the consumer near the ring end. A second producer write then crosses address 0. The random phase repeats this with batch lengths of 1 to 7 on an 8-entry ring, so both wrap and non-wrap batches occur often. Halt and enable-off stalls are checked by waiting many cycles with work pending and confirming that no move appears.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int ADDR_W = 32;
  localparam int DESC_W = 64;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] RA_CTRL = 4'd0;
  localparam logic [REG_AW-1:0] RA_RST  = 4'd1;
  localparam logic [REG_AW-1:0] RA_HALT = 4'd2;
  localparam logic [REG_AW-1:0] RA_BASE = 4'd3;
  localparam logic [REG_AW-1:0] RA_SIZE = 4'd4;
  localparam logic [REG_AW-1:0] RA_PROD = 4'd5;
  localparam logic [REG_AW-1:0] RA_CONS = 4'd6;
  localparam logic [REG_AW-1:0] RA_IEN  = 4'd7;
  localparam logic [REG_AW-1:0] RA_STAT = 4'd8;
  localparam logic [REG_AW-1:0] RA_CLR  = 4'd9;

  localparam int ST_DONE  = 0;
  localparam int ST_EMPTY = 3;
  localparam int ST_ERR   = 4;
  localparam int ST_EOT   = 5;
  localparam int ST_W     = 6;

  // flag bit positions within bits 63:48 of a descriptor
  localparam int FL_INT = 15;
  localparam int FL_EOT = 14;
  localparam int FL_EOB = 13;
  localparam int FL_NWD = 12;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_MOVE} ringStateT;

  typedef struct packed {
    logic capture;
    logic advance;
  } ringStrobeT;
endpackage

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import ring_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pipeClr,
  input  logic       runOk,
  input  logic       memRdValid,
  input  logic       moveDone,
  output ringStrobeT strobe,
  output logic       memRdReq,
  output logic       moveReq
);
  ringStateT state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (runOk) stateNext = S_FETCH;
      S_FETCH: if (memRdValid) stateNext = S_MOVE;
      S_MOVE:  if (moveDone) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
    if (pipeClr) stateNext = S_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign memRdReq       = (state == S_FETCH);
  assign moveReq        = (state == S_MOVE);
  assign strobe.capture = (state == S_FETCH) && memRdValid && !pipeClr;
  assign strobe.advance = (state == S_MOVE) && moveDone && !pipeClr;

  p_excl_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRdReq, moveReq}));

  p_move_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (moveReq && !moveDone && !pipeClr) |=> moveReq);

  p_no_fetch_stalled_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !runOk) |=> !memRdReq);
endmodule

// File: rtl/ring_dpath.sv
module ring_dpath
  import ring_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  ringStrobeT        strobe,
  input  logic [DESC_W-1:0] memRdData,
  output logic              runOk,
  output logic              pipeClr,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] descAddr,
  output logic [15:0]       descLen,
  output logic [3:0]        descFlags,
  output logic              ctrlDir,
  output logic              ctrlSys,
  output logic              irq
);
  localparam int SUM_W = OFF_W + 1;

  logic              pipeRst, haltReg, ctrlEn;
  logic [ADDR_W-4:0] ringBase;
  logic [OFF_W-1:0]  ringSize, prodOff, consOff, consNext;
  logic [ST_W-1:0]   irqEn, irqStat, setMask, clrMask;
  logic [SUM_W-1:0]  consSum;
  logic              wrProd, badProd;

  assign consSum  = {1'b0, consOff} + SUM_W'(8);
  assign consNext = (consSum >= {1'b0, ringSize}) ? '0 : consSum[OFF_W-1:0];
  assign wrProd   = regWrEn && (regAddr == RA_PROD);
  assign badProd  = (regWrData[2:0] != 3'd0) || (regWrData[OFF_W-1:0] >= ringSize);

  always_comb begin
    setMask = '0;
    if (strobe.advance) begin
      setMask[ST_DONE]  = descFlags[FL_INT-12];
      setMask[ST_EOT]   = descFlags[FL_EOT-12];
      setMask[ST_EMPTY] = (consNext == prodOff);
    end
    if (wrProd && badProd) setMask[ST_ERR] = 1'b1;
    clrMask = (regWrEn && regAddr == RA_CLR) ? regWrData[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeRst <= 1'b0; haltReg <= 1'b0; ctrlEn <= 1'b0; ctrlDir <= 1'b0; ctrlSys <= 1'b0;
      ringBase <= '0; ringSize <= '0; prodOff <= '0; consOff <= '0;
      irqEn <= '0; irqStat <= '0; descAddr <= '0; descLen <= '0; descFlags <= '0;
    end else begin
      if (regWrEn && regAddr == RA_RST) pipeRst <= regWrData[0];
      if (pipeRst) begin
        haltReg <= 1'b0; ctrlEn <= 1'b0; ctrlDir <= 1'b0; ctrlSys <= 1'b0;
        ringBase <= '0; ringSize <= '0; prodOff <= '0; consOff <= '0;
        irqEn <= '0; irqStat <= '0; descAddr <= '0; descLen <= '0; descFlags <= '0;
      end else begin
        if (regWrEn) begin
          unique case (regAddr)
            RA_CTRL: begin
              ctrlEn  <= regWrData[1];
              ctrlDir <= regWrData[3];
              ctrlSys <= regWrData[5];
            end
            RA_HALT: haltReg  <= regWrData[0];
            RA_BASE: ringBase <= regWrData[ADDR_W-1:3];
            RA_SIZE: ringSize <= regWrData[OFF_W-1:0];
            RA_PROD: if (!badProd) prodOff <= regWrData[OFF_W-1:0];
            RA_IEN:  irqEn    <= regWrData[ST_W-1:0];
            default: ;
          endcase
        end
        if (strobe.capture) begin
          descAddr  <= memRdData[31:0];
          descLen   <= memRdData[47:32];
          descFlags <= memRdData[63:60];
        end
        if (strobe.advance) consOff <= consNext;
        irqStat <= (irqStat & ~clrMask) | setMask;
      end
    end
  end

  assign pipeClr   = pipeRst;
  assign runOk     = ctrlEn && !haltReg && !pipeRst && (consOff != prodOff);
  assign memRdAddr = {ringBase, 3'b000} + ADDR_W'(consOff);
  assign irq       = |(irqStat & irqEn);

  always_comb begin
    unique case (regAddr)
      RA_CTRL: regRdData = {26'd0, ctrlSys, 1'b0, ctrlDir, 1'b0, ctrlEn, 1'b0};
      RA_RST:  regRdData = {31'd0, pipeRst};
      RA_HALT: regRdData = {31'd0, haltReg};
      RA_BASE: regRdData = {ringBase, 3'b000};
      RA_SIZE: regRdData = 32'(ringSize);
      RA_PROD: regRdData = 32'(prodOff);
      RA_CONS: regRdData = 32'(consOff);
      RA_IEN:  regRdData = 32'(irqEn);
      RA_STAT: regRdData = 32'(irqStat);
      default: regRdData = '0;
    endcase
  end

  p_cons_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    consOff[2:0] == 3'd0);

  p_cons_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !pipeRst) |=> (consOff == $past(consOff) + OFF_W'(8)) || (consOff == '0));

  p_bad_prod_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrProd && badProd && !pipeRst) |=> irqStat[ST_ERR] && (prodOff == $past(prodOff)));
endmodule

// File: rtl/ring_pipe_engine.sv
module ring_pipe_engine
  import ring_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memRdReq,
  output logic [31:0] memRdAddr,
  input  logic        memRdValid,
  input  logic [63:0] memRdData,
  output logic        moveReq,
  output logic [31:0] moveAddr,
  output logic [15:0] moveLen,
  output logic        moveDir,
  output logic        moveSysMode,
  output logic        moveFence,
  output logic        moveEob,
  input  logic        moveDone,
  output logic        irq
);
  ringStrobeT strobe;
  logic       runOk, pipeClr;
  logic [3:0] descFlags;

  ring_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .pipeClr(pipeClr), .runOk(runOk),
    .memRdValid(memRdValid), .moveDone(moveDone), .strobe(strobe),
    .memRdReq(memRdReq), .moveReq(moveReq)
  );

  ring_dpath #(.OFF_W(OFF_W)) i_dpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .memRdData(memRdData), .runOk(runOk), .pipeClr(pipeClr),
    .memRdAddr(memRdAddr), .descAddr(moveAddr), .descLen(moveLen),
    .descFlags(descFlags), .ctrlDir(moveDir), .ctrlSys(moveSysMode), .irq(irq)
  );

  assign moveFence = descFlags[FL_NWD-12];
  assign moveEob   = descFlags[FL_EOB-12];
endmodule

// File: tb/test_ring_pipe_engine.sv
module test_ring_pipe_engine;
  logic        clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0;
  logic [3:0]  regAddr = 4'd0;
  logic [31:0] regWrData = '0, regRdData, memRdAddr, moveAddr;
  logic        memRdReq, memRdValid = 1'b0, moveReq, moveDone = 1'b0;
  logic [63:0] memRdData = '0;
  logic [15:0] moveLen;
  logic        moveDir, moveSysMode, moveFence, moveEob, irq;

  ring_pipe_engine i_ring_pipe_engine (.*);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  logic [63:0] ringMem [0:31];
  logic [31:0] logAddr [0:63], fetchLog [0:63];
  logic [15:0] logLen [0:63];
  logic [3:0]  logBits [0:63];
  int logCnt = 0, fetchCnt = 0;
  bit memBusy = 0, mvBusy = 0;
  int memCnt = 0, mvCnt = 0;
  localparam logic [31:0] BASE = 32'h1000;
  localparam int RSIZE = 64;

  always @(negedge clk) begin
    if (memRdValid) begin memRdValid = 1'b0; memBusy = 0; end
    else if (memBusy) begin
      if (memCnt == 0) begin
        memRdValid = 1'b1;
        memRdData = ringMem[5'((memRdAddr - BASE) >> 3)];
      end else memCnt--;
    end else if (memRdReq) begin
      if (fetchCnt < 64) fetchLog[fetchCnt] = memRdAddr;
      fetchCnt++; memBusy = 1; memCnt = $urandom_range(0, 2);
    end
  end

  always @(negedge clk) begin
    if (moveDone) moveDone = 1'b0;
    else if (mvBusy) begin
      if (mvCnt == 0) begin moveDone = 1'b1; mvBusy = 0; end else mvCnt--;
    end else if (moveReq) begin
      if (logCnt < 64) begin
        logAddr[logCnt] = moveAddr; logLen[logCnt] = moveLen;
        logBits[logCnt] = {moveDir, moveSysMode, moveFence, moveEob};
      end
      logCnt++; mvBusy = 1; mvCnt = $urandom_range(0, 3);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdData;
  endtask

  task automatic waitIdle(input int target);
    logic [31:0] c;
    for (int i = 0; i < 3000; i++) begin
      regRead(4'd6, c);
      if (c[15:0] == 16'(target) && !moveReq && !memRdReq && !memBusy && !mvBusy) break;
    end
    repeat (4) @(negedge clk);
  endtask

  // fill descriptors from byte offset start, k entries, with given flags; returns expected status
  function automatic logic [5:0] fill(input int start, input int k, input logic [15:0] fl [0:7],
                                      output logic [31:0] ea [0:7], output logic [15:0] el [0:7]);
    logic [5:0] st = 6'h08;
    for (int i = 0; i < k; i++) begin
      int idx = ((start / 8) + i) % (RSIZE / 8);
      ea[i] = $urandom; el[i] = 16'($urandom);
      ringMem[idx] = {fl[i], el[i], ea[i]};
      if (fl[i][15]) st[0] = 1'b1;
      if (fl[i][14]) st[5] = 1'b1;
    end
    return st;
  endfunction

  task automatic runBatch(input string tag, input int start, input int k,
                          input logic [15:0] fl [0:7], input bit dir, input bit sys);
    logic [31:0] ea [0:7], rd;
    logic [15:0] el [0:7];
    logic [5:0]  est;
    int endOff = (start + 8 * k) % RSIZE;
    est = fill(start, k, fl, ea, el);
    logCnt = 0; fetchCnt = 0;
    regWrite(4'd5, 32'(endOff));
    waitIdle(endOff);
    check(logCnt == k, "R3", {tag, " move count"}, 32'(logCnt), 32'(k));
    for (int i = 0; i < k && i < logCnt; i++) begin
      check(fetchLog[i] == BASE + 32'(((start / 8 + i) % (RSIZE / 8)) * 8), "R2",
            {tag, " fetch address"}, fetchLog[i], BASE + 32'(((start / 8 + i) % (RSIZE / 8)) * 8));
      check(logAddr[i] == ea[i] && logLen[i] == el[i], "R2", {tag, " move addr/len"},
            logAddr[i] ^ 32'(logLen[i]), ea[i] ^ 32'(el[i]));
      check(logBits[i] == {dir, sys, fl[i][12], fl[i][13]}, "R2", {tag, " move bits"},
            32'(logBits[i]), 32'({dir, sys, fl[i][12], fl[i][13]}));
    end
    regRead(4'd6, rd);
    check(rd[15:0] == 16'(endOff), "R4", {tag, " consumer wrap"}, rd, 32'(endOff));
    regRead(4'd8, rd);
    check(rd[5:0] == est, "R6", {tag, " status events (R7 empty bit)"}, rd, 32'(est));
    regWrite(4'd9, 32'h3F);
    regRead(4'd8, rd);
    check(rd == 0, "R8", {tag, " status clear"}, rd, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] fl [0:7];
    int cons;
    void'($urandom(32'd31));
    for (int i = 0; i < 32; i++) ringMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    regRead(4'd6, rd); check(rd == 0, "R1", "consumer after reset", rd, 0);
    regRead(4'd8, rd); check(rd == 0, "R1", "status after reset", rd, 0);
    check(!irq && !memRdReq && !moveReq, "R1", "outputs idle after reset",
          {29'd0, irq, memRdReq, moveReq}, 0);

    regWrite(4'd3, BASE | 32'h7);
    regRead(4'd3, rd); check(rd == BASE, "R11", "base low bits", rd, BASE);
    regWrite(4'd4, RSIZE);
    regWrite(4'd0, 32'h0A);

    fl[0] = 16'h8000; fl[1] = 16'h0000; fl[2] = 16'h7000;
    runBatch("R3 first batch", 0, 3, fl, 1'b1, 1'b0);

    for (int i = 0; i < 8; i++) fl[i] = 16'h0000;
    fl[3] = 16'h2000;
    regWrite(4'd0, 32'h22);
    runBatch("R4 wrap batch, R6 no events", 24, 6, fl, 1'b0, 1'b1);

    logCnt = 0;
    regWrite(4'd5, 32'd13);
    regRead(4'd8, rd); check(rd[4], "R5", "misaligned producer error", rd, 32'h10);
    regWrite(4'd5, RSIZE);
    regRead(4'd5, rd); check(rd == 8, "R5", "oversize producer ignored", rd, 8);
    repeat (30) @(negedge clk);
    check(logCnt == 0, "R5", "no move after bad producer", 32'(logCnt), 0);
    regWrite(4'd7, 32'h10);
    #1 check(irq, "R8", "irq with error enabled", {31'd0, irq}, 1);
    regWrite(4'd9, 32'h10);
    #1 check(!irq, "R8", "irq after clear", {31'd0, irq}, 0);
    regWrite(4'd7, 32'h00);

    regWrite(4'd2, 32'd1);
    ringMem[1] = {16'h8000, 16'd4, 32'hABCD0000};
    regWrite(4'd5, 32'd16);
    repeat (40) @(negedge clk);
    check(logCnt == 0, "R9", "halted pipe moves", 32'(logCnt), 0);
    regRead(4'd6, rd); check(rd == 8, "R9", "halted consumer", rd, 8);
    regWrite(4'd2, 32'd0);
    waitIdle(16);
    check(logCnt == 1 && logAddr[0] == 32'hABCD0000, "R9", "resume move", 32'(logCnt), 1);

    logCnt = 0;
    regWrite(4'd0, 32'h00);
    regWrite(4'd5, 32'd24);
    repeat (40) @(negedge clk);
    check(logCnt == 0, "R3", "disabled pipe moves", 32'(logCnt), 0);
    regWrite(4'd0, 32'h02);
    waitIdle(24);
    check(logCnt == 1, "R3", "re-enabled pipe moves", 32'(logCnt), 1);
    regWrite(4'd9, 32'h3F);

    cons = 24;
    for (int r = 0; r < 25; r++) begin
      int k = $urandom_range(1, 7);
      bit dir = 1'($urandom), sys = 1'($urandom);
      for (int i = 0; i < 8; i++) fl[i] = {4'($urandom), 12'd0};
      regWrite(4'd0, {26'd0, sys, 1'b0, dir, 1'b0, 1'b1, 1'b0});
      runBatch("R3 random", cons, k, fl, dir, sys);
      cons = (cons + 8 * k) % RSIZE;
    end

    regWrite(4'd7, 32'h3F);
    regWrite(4'd1, 32'd1);
    regWrite(4'd1, 32'd0);
    regRead(4'd6, rd); check(rd == 0, "R10", "consumer after pipe reset", rd, 0);
    regRead(4'd3, rd); check(rd == 0, "R10", "base after pipe reset", rd, 0);
    regRead(4'd4, rd); check(rd == 0, "R10", "size after pipe reset", rd, 0);
    regRead(4'd0, rd); check(rd == 0, "R10", "control after pipe reset", rd, 0);
    regRead(4'd7, rd); check(rd == 0, "R10", "enables after pipe reset", rd, 0);
    regRead(4'd5, rd); check(rd == 0, "R10", "producer after pipe reset", rd, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule